// File: doc/BRIEF.md
# Class-Priority Injection Scheduler

This block sits at the injection side of a network interface. It watches eight per-class packet queues and, whenever the output link is free, grants the highest-priority packet that the downstream buffer can take in full. The granted packet is then streamed out one 64-byte unit per beat. The class number travels with the packet as a priority field, so that switches further along can keep the injection order.

Downstream buffering is tracked with only two credit pools: one for the QoS virtual channel and one for the best-effort virtual channel. Classes 4 to 7 draw from the QoS pool and classes 0 to 3 draw from the best-effort pool. When a packet is granted, the pool is charged for the whole packet. The pool is refilled one unit for each credit-return pulse. Packets are never dropped: a class that lacks credit waits, and a lower class that does fit may go ahead of it.

Top module: `cls_inject_sched`

## Requirements
- R1: After reset the output is idle (`out_valid`=0, `req_ack`=0), and each pool holds its parameterized initial credit (16 units by default).
- R2: While the output is idle, the grant goes to the highest-numbered eligible class. It is shown as a one-hot pulse on `req_ack` in the same cycle that the request is seen.
- R3: Every beat carries the granted class on `out_prio`. `out_vc` is 1 (QoS channel) for classes 4 to 7 and 0 (best-effort channel) for classes 0 to 3.
- R4: A class is eligible only when its `req_units` value is no larger than the current credit of its group's pool. A class that is short of credit is skipped in favour of any lower class that fits, in either group.
- R5: A grant subtracts the packet's unit count from its group's pool. Each `ret_qos` or `ret_be` pulse adds one unit. A grant and a return in the same cycle both take effect.
- R6: A granted packet owns the output until its last beat. It sends exactly `req_units` beats, with `out_sop` on the first and `out_eop` on the last. While `out_ready` is low, the outputs hold steady, and no other grant is issued.
- R7: A request whose `req_units` field is 0 is ignored and never granted. Legal sizes are 1 to 32 units (64 to 2048 bytes, header included in the first unit).
- R8: The first beat appears the cycle after the grant. After the last beat is accepted, the next grant can be made in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-class packet waiting, bit c = class c |
| req_units | input | 48 | Per-class size in 64-byte units, class c in bits [6c+5:6c] |
| req_ack | output | 8 | One-hot grant pulse, pops the head packet of the class |
| out_ready | input | 1 | Link accepts the current beat |
| out_valid | output | 1 | Beat present |
| out_sop | output | 1 | First beat of a packet (header beat) |
| out_eop | output | 1 | Last beat of a packet |
| out_vc | output | 1 | Downstream channel: 1 = QoS, 0 = best effort |
| out_prio | output | 3 | Priority stamp equal to the class number |
| ret_qos | input | 1 | One credit unit returned to the QoS pool |
| ret_be | input | 1 | One credit unit returned to the best-effort pool |

## Verification
The assertions assume that the downstream side never returns more credit than was spent, so neither pool can rise above its initial value. They also assume that a requester keeps its `req_valid` and `req_units` steady until it is acknowledged. The stimulus keeps to both assumptions. It returns only the units the bench's own model records as owed. It changes a class's request only away from the clock edge, and it drops the request once the grant pulse has been seen.

// File: rtl/cls_inject_sched.sv
module cls_inject_sched #(
  parameter int N_CLASS  = 8,
  parameter int UNIT_W   = 6,
  parameter int POOL_W   = 8,
  parameter int QOS_INIT = 16,
  parameter int BE_INIT  = 16,
  parameter int QOS_BASE = 4,
  localparam int PRIO_W  = $clog2(N_CLASS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CLASS-1:0]        req_valid,
  input  logic [N_CLASS*UNIT_W-1:0] req_units,
  output logic [N_CLASS-1:0]        req_ack,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic                      out_sop,
  output logic                      out_eop,
  output logic                      out_vc,
  output logic [PRIO_W-1:0]         out_prio,
  input  logic                      ret_qos,
  input  logic                      ret_be
);

  logic              busy_q, first_q;
  logic [PRIO_W-1:0] cls_q;
  logic [UNIT_W-1:0] left_q;
  logic [POOL_W-1:0] pool_qos_q, pool_be_q;

  logic [N_CLASS-1:0] elig;
  logic               any_elig, grant, win_qos, beat;
  logic [PRIO_W-1:0]  win_idx;
  logic [UNIT_W-1:0]  win_units;
  logic [POOL_W-1:0]  spend_qos, spend_be;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_elig
    logic [UNIT_W-1:0] u;
    logic [POOL_W-1:0] avail;
    assign u     = req_units[c*UNIT_W +: UNIT_W];
    assign avail = (c >= QOS_BASE) ? pool_qos_q : pool_be_q;
    assign elig[c] = req_valid[c] && (u != '0) && (POOL_W'(u) <= avail);

    assert property (@(posedge clk) disable iff (!rst_n)
      req_ack[c] |-> (u != '0))
      else $error("assert_zero_ignored_R7");
  end

  always_comb begin
    win_idx = '0;
    for (int c = 0; c < N_CLASS; c++)
      if (elig[c]) win_idx = PRIO_W'(c);
  end

  assign any_elig  = |elig;
  assign grant     = !busy_q && any_elig;
  assign req_ack   = grant ? (N_CLASS'(1) << win_idx) : '0;
  assign win_units = req_units[win_idx*UNIT_W +: UNIT_W];
  assign win_qos   = (win_idx >= PRIO_W'(QOS_BASE));
  assign spend_qos = (grant && win_qos)  ? POOL_W'(win_units) : '0;
  assign spend_be  = (grant && !win_qos) ? POOL_W'(win_units) : '0;
  assign beat      = busy_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pool_qos_q <= POOL_W'(QOS_INIT);
      pool_be_q  <= POOL_W'(BE_INIT);
    end else begin
      pool_qos_q <= pool_qos_q - spend_qos + POOL_W'(ret_qos);
      pool_be_q  <= pool_be_q  - spend_be  + POOL_W'(ret_be);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cls_q   <= '0;
      left_q  <= '0;
    end else if (grant) begin
      busy_q  <= 1'b1;
      first_q <= 1'b1;
      cls_q   <= win_idx;
      left_q  <= win_units;
    end else if (beat) begin
      first_q <= 1'b0;
      left_q  <= left_q - 1'b1;
      if (left_q == UNIT_W'(1)) busy_q <= 1'b0;
    end
  end

  assign out_valid = busy_q;
  assign out_sop   = busy_q && first_q;
  assign out_eop   = busy_q && (left_q == UNIT_W'(1));
  assign out_prio  = cls_q;
  assign out_vc    = (cls_q >= PRIO_W'(QOS_BASE));

  assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_ack))
    else $error("assert_ack_onehot_R2");

  assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack != '0) |=> out_valid && out_sop && ((N_CLASS'(1) << out_prio) == $past(req_ack)))
    else $error("assert_first_beat_R8");

  assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prio) && $stable(out_sop) && $stable(out_eop))
    else $error("assert_hold_on_stall_R6");

  assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop && out_ready |=> !out_valid)
    else $error("assert_release_after_eop_R6");

  assert property (@(posedge clk) disable iff (!rst_n)
    (pool_qos_q <= POOL_W'(QOS_INIT)) && (pool_be_q <= POOL_W'(BE_INIT)))
    else $error("assert_pool_bound_R5");

endmodule

// File: tb/cls_inject_sched_tb.sv
module cls_inject_sched_tb_top;
  typedef int ua_t[8];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_valid = '0;
  logic [47:0] req_units = '0;
  logic [7:0]  req_ack;
  logic        out_ready = 1'b0;
  logic        out_valid, out_sop, out_eop, out_vc;
  logic [2:0]  out_prio;
  logic        ret_qos = 1'b0, ret_be = 1'b0;

  int checks = 0, fails = 0;
  int mpool[2];
  bit done = 0;

  always #4 clk = ~clk;

  cls_inject_sched dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_units(req_units),
    .req_ack(req_ack), .out_ready(out_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_vc(out_vc), .out_prio(out_prio),
    .ret_qos(ret_qos), .ret_be(ret_be));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_win(logic [7:0] v, ua_t u);
    int w = -1;
    for (int c = 0; c < 8; c++)
      if (v[c] && u[c] != 0 && u[c] <= mpool[c >= 4 ? 1 : 0]) w = c;
    return w;
  endfunction

  task automatic send_pkt(logic [7:0] v, ua_t u, bit stall, bit rq);
    int w;
    @(negedge clk);
    for (int c = 0; c < 8; c++) req_units[c*6 +: 6] = u[c][5:0];
    req_valid = v;
    ret_qos = rq;
    #1;
    w = exp_win(v, u);
    if (w < 0) begin
      chk(req_ack == 8'h00, "R4/R7 no grant", req_ack, 0);
      @(negedge clk);
      ret_qos = 1'b0;
      if (rq) mpool[1]++;
      chk(req_ack == 8'h00 && !out_valid, "R4/R7 still idle", req_ack, 0);
      req_valid = '0;
      return;
    end
    chk(req_ack == (8'h01 << w), "R2 grant pick", req_ack, 8'h01 << w);
    mpool[w >= 4 ? 1 : 0] -= u[w];
    if (rq) mpool[1]++;
    @(negedge clk);
    ret_qos = 1'b0;
    req_valid = '0;
    chk(out_valid && out_sop, "R8 first beat next cycle", out_valid, 1);
    chk(out_prio == w[2:0], "R3 priority stamp", out_prio, w);
    chk(out_vc == (w >= 4), "R3 vc select", out_vc, w >= 4);
    if (stall) begin
      out_ready = 1'b0;
      @(negedge clk);
      chk(out_valid && out_sop && out_prio == w[2:0], "R6 hold on stall", out_prio, w);
    end
    for (int b = 0; b < u[w]; b++) begin
      out_ready = 1'b1;
      chk(out_valid && out_prio == w[2:0], "R6 beat prio", out_prio, w);
      chk(out_sop == (b == 0), "R6 sop position", out_sop, b == 0);
      chk(out_eop == (b == u[w] - 1), "R6 eop position", out_eop, b == u[w] - 1);
      chk(req_ack == 8'h00, "R6 no grant while busy", req_ack, 0);
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!out_valid, "R6 released after eop", out_valid, 0);
  endtask

  task automatic give_back(int q, int b);
    int n = q > b ? q : b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ret_qos = (i < q);
      ret_be  = (i < b);
    end
    @(negedge clk);
    ret_qos = 1'b0;
    ret_be  = 1'b0;
    mpool[1] += q;
    mpool[0] += b;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    ua_t u;
    mpool[0] = 16;
    mpool[1] = 16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && req_ack == 8'h00, "R1 reset idle", out_valid, 0);

    // R1: full initial pools accept a 16-unit packet, 17 is refused
    u = '{default: 0};
    u[3] = 17; u[0] = 16;
    send_pkt(8'h09, u, 0, 0);
    give_back(0, 16);
    u = '{default: 0};
    u[7] = 16;
    send_pkt(8'h80, u, 1, 0);
    give_back(16, 0);

    // R7: zero-sized request ignored
    u = '{default: 0};
    u[7] = 0; u[1] = 2;
    send_pkt(8'h82, u, 0, 0);
    u = '{default: 0};
    send_pkt(8'h20, u, 0, 0);
    give_back(0, 2);

    // R5: grant and return in the same cycle
    u = '{default: 0};
    u[6] = 10;
    send_pkt(8'h40, u, 0, 0);
    u = '{default: 0};
    u[4] = 4;
    send_pkt(8'h10, u, 0, 1);
    chk(mpool[1] == 3, "R5 model pool", mpool[1], 3);
    u = '{default: 0};
    u[7] = 4; u[5] = 3;
    send_pkt(8'hA0, u, 0, 0);
    chk(mpool[1] == 0, "R5 pool drained", mpool[1], 0);
    give_back(16, 0);

    // R2/R4 sweep over every request pattern
    for (int pat = 0; pat < 256; pat++) begin
      for (int c = 0; c < 8; c++) u[c] = (pat * 7 + c * 11) % 20;
      send_pkt(pat[7:0], u, pat % 5 == 0, 0);
      if (pat % 4 == 3) give_back(16 - mpool[1], 16 - mpool[0]);
      else give_back(mpool[1] < 16 ? 1 : 0, mpool[0] < 16 ? 1 : 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule